// File: doc/BRIEF.md
# ModR/M effective address generator

This block decodes the memory operand of a 16-bit real-mode instruction. It takes the opcode byte, the ModR/M byte and up to two displacement bytes, together with the current values of BX, BP, SI, DI, DS and SS. From these it forms the 16-bit effective address, the 20-bit physical address and the segment that was used. It also reports how many displacement bytes the operand takes, whether R/M names a register, the transfer direction, the operand size, and which registers the REG field and a register R/M field name.

An issue stage presents one operand per cycle with `in_valid`. Every result appears registered one cycle later, qualified by `out_valid`. A segment override, once taken from a prefix byte, can be applied through `ovr_en` and `ovr_seg`.

Top module: `modrm_ea_gen`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by one clock, and all other outputs carry the result for the operand presented in that earlier cycle. A synchronous reset drives every output to zero.
- R2: ModR/M bits [7:6] are the mode. Mode 00 adds no displacement. Mode 01 adds `disp_lo` sign-extended to 16 bits and gives `disp_len`=1. Mode 10 adds `{disp_hi,disp_lo}` and gives `disp_len`=2.
- R3: ModR/M bits [2:0] choose the address terms. 000 gives BX+SI, 001 gives BX+DI, 010 gives BP+SI and 011 gives BP+DI. 100 gives SI, 101 gives DI, 110 gives BP and 111 gives BX.
- R4: Mode 00 with R/M 110 is a direct address: `ea`={disp_hi,disp_lo}, `disp_len`=2, no base register, and DS is the default segment.
- R5: `seg_sel` encodes 0 for DS, 1 for SS and 2 for the override. R/M 010, 011, and 110 outside mode 00, default to SS. Every other memory form defaults to DS.
- R6: When `ovr_en` is 1, every memory form uses `ovr_seg` as its segment and reports `seg_sel`=2.
- R7: `ea` is the sum taken modulo 2^16. `pa` = segment*16 + `ea`, truncated to 20 bits.
- R8: Mode 11 sets `is_reg`=1, `disp_len`=0, and `ea`, `pa` and `seg_sel` to 0. It sets `rm_reg_id`={W,R/M}. In every memory form `rm_reg_id` is 0 and `is_reg` is 0.
- R9: `dir_to_reg` is opcode bit 1 and `is_word` is opcode bit 0. `reg_id`={W, ModR/M[5:3]}. Values 0-7 name AL,CL,DL,BL,AH,CH,DH,BH and values 8-15 name AX,CX,DX,BX,SP,BP,SI,DI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand presented this cycle |
| opcode | input | 8 | Opcode byte (bit 1 direction, bit 0 size) |
| modrm | input | 8 | ModR/M byte |
| disp_lo | input | 8 | First displacement byte |
| disp_hi | input | 8 | Second displacement byte |
| reg_bx | input | 16 | Current BX |
| reg_bp | input | 16 | Current BP |
| reg_si | input | 16 | Current SI |
| reg_di | input | 16 | Current DI |
| seg_ds | input | 16 | Current DS |
| seg_ss | input | 16 | Current SS |
| ovr_en | input | 1 | Apply segment override |
| ovr_seg | input | 16 | Override segment value |
| out_valid | output | 1 | Result valid |
| is_reg | output | 1 | R/M names a register |
| disp_len | output | 2 | Displacement bytes consumed |
| dir_to_reg | output | 1 | Destination is the REG operand |
| is_word | output | 1 | Word-sized operand |
| reg_id | output | 4 | Register named by REG field |
| rm_reg_id | output | 4 | Register named by R/M in mode 11 |
| seg_sel | output | 2 | Segment used |
| ea | output | 16 | Effective address |
| pa | output | 20 | Physical address |

## Verification
The bench sweeps every ModR/M value and every direction/size bit pair. It does this under several register sets, with and without override, and compares each output against an arithmetic model. The register values are chosen to hit the corner cases. One is a negative 8-bit displacement: a design that zero-extends it would give an address 256 too high. Another is a set of sums that pass 0xFFFF, and a segment near 0xFFFF that pushes the physical sum past 20 bits. A wrong modulo would leak a carry into a higher bit. The direct-address form is checked on its own: a design that still adds BP there, or picks SS for it, would show a wrong `ea` or `seg_sel`.

// File: rtl/modrm_ea_pkg.sv
package modrm_ea_pkg;

    typedef enum logic [1:0] {
        SEG_DS  = 2'd0,
        SEG_SS  = 2'd1,
        SEG_OVR = 2'd2
    } seg_sel_e;

    typedef enum logic [1:0] {
        MODE_NODISP = 2'b00,
        MODE_DISP8  = 2'b01,
        MODE_DISP16 = 2'b10,
        MODE_REG    = 2'b11
    } mode_e;

    localparam logic [2:0] RM_DIRECT = 3'b110;

    typedef struct packed {
        logic       is_reg;
        logic [1:0] disp_len;
        logic       dir_to_reg;
        logic       is_word;
        logic [3:0] reg_id;
        logic [3:0] rm_reg_id;
    } dec_t;

    function automatic logic [1:0] disp_bytes(input mode_e mode, input logic [2:0] rm);
        case (mode)
            MODE_DISP8:  return 2'd1;
            MODE_DISP16: return 2'd2;
            MODE_NODISP: return (rm == RM_DIRECT) ? 2'd2 : 2'd0;
            default:     return 2'd0;
        endcase
    endfunction

    function automatic logic stack_default(input mode_e mode, input logic [2:0] rm);
        case (rm)
            3'b010, 3'b011: return 1'b1;
            RM_DIRECT:      return (mode != MODE_NODISP);
            default:        return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/modrm_field_dec.sv
module modrm_field_dec
    import modrm_ea_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic [7:0] modrm,
    output mode_e      mode,
    output logic [2:0] rm,
    output dec_t       dec
);
    always_comb begin
        mode           = mode_e'(modrm[7:6]);
        rm             = modrm[2:0];
        dec.is_reg     = (mode == MODE_REG);
        dec.disp_len   = disp_bytes(mode, rm);
        dec.dir_to_reg = opcode[1];
        dec.is_word    = opcode[0];
        dec.reg_id     = {opcode[0], modrm[5:3]};
        dec.rm_reg_id  = dec.is_reg ? {opcode[0], rm} : 4'd0;
    end
endmodule

// File: rtl/modrm_ea_calc.sv
module modrm_ea_calc
    import modrm_ea_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  mode_e              mode,
    input  logic [2:0]         rm,
    input  logic [7:0]         disp_lo,
    input  logic [7:0]         disp_hi,
    input  logic [ADDR_W-1:0]  reg_bx,
    input  logic [ADDR_W-1:0]  reg_bp,
    input  logic [ADDR_W-1:0]  reg_si,
    input  logic [ADDR_W-1:0]  reg_di,
    output logic [ADDR_W-1:0]  ea,
    output logic               use_stack
);
    logic [ADDR_W-1:0] base_t, index_t, disp_t;

    always_comb begin
        case (rm)
            3'b000, 3'b001, 3'b111: base_t = reg_bx;
            3'b010, 3'b011:         base_t = reg_bp;
            RM_DIRECT:              base_t = (mode == MODE_NODISP) ? '0 : reg_bp;
            default:                base_t = '0;
        endcase
        case (rm)
            3'b000, 3'b010, 3'b100: index_t = reg_si;
            3'b001, 3'b011, 3'b101: index_t = reg_di;
            default:                index_t = '0;
        endcase
        case (mode)
            MODE_DISP8:  disp_t = ADDR_W'($signed(disp_lo));
            MODE_DISP16: disp_t = ADDR_W'({disp_hi, disp_lo});
            MODE_NODISP: disp_t = (rm == RM_DIRECT) ? ADDR_W'({disp_hi, disp_lo}) : '0;
            default:     disp_t = '0;
        endcase
        ea        = base_t + index_t + disp_t;
        use_stack = stack_default(mode, rm);
    end
endmodule

// File: rtl/modrm_pa_calc.sv
module modrm_pa_calc
    import modrm_ea_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned SEG_SHIFT = 4,
    parameter int unsigned PHYS_W    = 20
) (
    input  logic               is_reg,
    input  logic               use_stack,
    input  logic               ovr_en,
    input  logic [ADDR_W-1:0]  ovr_seg,
    input  logic [ADDR_W-1:0]  seg_ds,
    input  logic [ADDR_W-1:0]  seg_ss,
    input  logic [ADDR_W-1:0]  ea,
    output logic [PHYS_W-1:0]  pa,
    output seg_sel_e           seg_sel
);
    localparam int unsigned SHW = ADDR_W + SEG_SHIFT;

    logic [ADDR_W-1:0] seg_val;
    logic [SHW-1:0]    seg_base;

    always_comb begin
        if (ovr_en) begin
            seg_sel = SEG_OVR;
            seg_val = ovr_seg;
        end else if (use_stack) begin
            seg_sel = SEG_SS;
            seg_val = seg_ss;
        end else begin
            seg_sel = SEG_DS;
            seg_val = seg_ds;
        end
        seg_base = {seg_val, {SEG_SHIFT{1'b0}}};
        pa       = PHYS_W'(seg_base) + PHYS_W'(ea);
        if (is_reg) begin
            seg_sel = SEG_DS;
            pa      = '0;
        end
    end
endmodule

// File: rtl/modrm_ea_gen.sv
module modrm_ea_gen
    import modrm_ea_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned SEG_SHIFT = 4,
    parameter int unsigned PHYS_W    = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [7:0]         opcode,
    input  logic [7:0]         modrm,
    input  logic [7:0]         disp_lo,
    input  logic [7:0]         disp_hi,
    input  logic [ADDR_W-1:0]  reg_bx,
    input  logic [ADDR_W-1:0]  reg_bp,
    input  logic [ADDR_W-1:0]  reg_si,
    input  logic [ADDR_W-1:0]  reg_di,
    input  logic [ADDR_W-1:0]  seg_ds,
    input  logic [ADDR_W-1:0]  seg_ss,
    input  logic               ovr_en,
    input  logic [ADDR_W-1:0]  ovr_seg,
    output logic               out_valid,
    output logic               is_reg,
    output logic [1:0]         disp_len,
    output logic               dir_to_reg,
    output logic               is_word,
    output logic [3:0]         reg_id,
    output logic [3:0]         rm_reg_id,
    output logic [1:0]         seg_sel,
    output logic [ADDR_W-1:0]  ea,
    output logic [PHYS_W-1:0]  pa
);
    mode_e             mode_c;
    logic [2:0]        rm_c;
    dec_t              dec_c;
    logic [ADDR_W-1:0] ea_raw, ea_c;
    logic              stack_c;
    logic [PHYS_W-1:0] pa_c;
    seg_sel_e          seg_c;

    modrm_field_dec u_dec (
        .opcode (opcode),
        .modrm  (modrm),
        .mode   (mode_c),
        .rm     (rm_c),
        .dec    (dec_c)
    );

    modrm_ea_calc #(.ADDR_W(ADDR_W)) u_ea (
        .mode      (mode_c),
        .rm        (rm_c),
        .disp_lo   (disp_lo),
        .disp_hi   (disp_hi),
        .reg_bx    (reg_bx),
        .reg_bp    (reg_bp),
        .reg_si    (reg_si),
        .reg_di    (reg_di),
        .ea        (ea_raw),
        .use_stack (stack_c)
    );

    assign ea_c = dec_c.is_reg ? '0 : ea_raw;

    modrm_pa_calc #(
        .ADDR_W    (ADDR_W),
        .SEG_SHIFT (SEG_SHIFT),
        .PHYS_W    (PHYS_W)
    ) u_pa (
        .is_reg    (dec_c.is_reg),
        .use_stack (stack_c),
        .ovr_en    (ovr_en),
        .ovr_seg   (ovr_seg),
        .seg_ds    (seg_ds),
        .seg_ss    (seg_ss),
        .ea        (ea_c),
        .pa        (pa_c),
        .seg_sel   (seg_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            is_reg     <= 1'b0;
            disp_len   <= 2'd0;
            dir_to_reg <= 1'b0;
            is_word    <= 1'b0;
            reg_id     <= 4'd0;
            rm_reg_id  <= 4'd0;
            seg_sel    <= 2'd0;
            ea         <= '0;
            pa         <= '0;
        end else begin
            out_valid  <= in_valid;
            is_reg     <= dec_c.is_reg;
            disp_len   <= dec_c.disp_len;
            dir_to_reg <= dec_c.dir_to_reg;
            is_word    <= dec_c.is_word;
            reg_id     <= dec_c.reg_id;
            rm_reg_id  <= dec_c.rm_reg_id;
            seg_sel    <= seg_c;
            ea         <= ea_c;
            pa         <= pa_c;
        end
    end
endmodule

// File: rtl/modrm_ea_chk.sv
module modrm_ea_chk #(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned SEG_SHIFT = 4,
    parameter int unsigned PHYS_W    = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [7:0]        modrm,
    input logic              ovr_en,
    input logic              out_valid,
    input logic              is_reg,
    input logic [1:0]        disp_len,
    input logic [1:0]        seg_sel,
    input logic [ADDR_W-1:0] ea,
    input logic [PHYS_W-1:0] pa
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && pa == '0 && ea == '0));

    // R8
    reg_form_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && is_reg) |-> (disp_len == 2'd0 && ea == '0 && pa == '0));

    // R7
    low_nibble_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !is_reg) |-> (pa[SEG_SHIFT-1:0] == ea[SEG_SHIFT-1:0]));

    // R6
    override_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !is_reg && $past(ovr_en)) |-> (seg_sel == 2'd2));

    // R5
    stack_default_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(ovr_en) && $past(modrm[7:6]) != 2'b11 && $past(modrm[7:6]) != 2'b00
         && ($past(modrm[2:0]) == 3'b010 || $past(modrm[2:0]) == 3'b011 || $past(modrm[2:0]) == 3'b110))
        |-> (seg_sel == 2'd1));

    // R4
    direct_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(modrm[7:6]) == 2'b00 && $past(modrm[2:0]) == 3'b110 && !$past(ovr_en))
        |-> (disp_len == 2'd2 && seg_sel == 2'd0));
endmodule

bind modrm_ea_gen modrm_ea_chk #(
    .ADDR_W    (ADDR_W),
    .SEG_SHIFT (SEG_SHIFT),
    .PHYS_W    (PHYS_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .modrm     (modrm),
    .ovr_en    (ovr_en),
    .out_valid (out_valid),
    .is_reg    (is_reg),
    .disp_len  (disp_len),
    .seg_sel   (seg_sel),
    .ea        (ea),
    .pa        (pa)
);

// File: tb/modrm_ea_gen_bench.sv
module modrm_ea_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  opcode = 8'h00, modrm = 8'h00, disp_lo = 8'h00, disp_hi = 8'h00;
    logic [15:0] reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0;
    logic [15:0] seg_ds = '0, seg_ss = '0, ovr_seg = '0;
    logic        ovr_en = 1'b0;
    logic        out_valid, is_reg, dir_to_reg, is_word;
    logic [1:0]  disp_len, seg_sel;
    logic [3:0]  reg_id, rm_reg_id;
    logic [15:0] ea;
    logic [19:0] pa;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    modrm_ea_gen u_modrm_ea_gen (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode), .modrm(modrm),
        .disp_lo(disp_lo), .disp_hi(disp_hi), .reg_bx(reg_bx), .reg_bp(reg_bp),
        .reg_si(reg_si), .reg_di(reg_di), .seg_ds(seg_ds), .seg_ss(seg_ss),
        .ovr_en(ovr_en), .ovr_seg(ovr_seg), .out_valid(out_valid), .is_reg(is_reg),
        .disp_len(disp_len), .dir_to_reg(dir_to_reg), .is_word(is_word),
        .reg_id(reg_id), .rm_reg_id(rm_reg_id), .seg_sel(seg_sel), .ea(ea), .pa(pa)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (modrm=%02h op=%02h ovr=%0d)",
                     req, act, exp, modrm, opcode, ovr_en);
        end
    endtask

    task automatic load_pattern(input int p);
        case (p)
            0: begin
                reg_bx = 16'h1234; reg_bp = 16'hFFF0; reg_si = 16'h0011; reg_di = 16'h8000;
                seg_ds = 16'hF000; seg_ss = 16'hABCD; disp_lo = 8'h80; disp_hi = 8'h7F;
                ovr_seg = 16'h0123;
            end
            1: begin
                reg_bx = 16'hFFFF; reg_bp = 16'h0001; reg_si = 16'hFFFF; reg_di = 16'h0002;
                seg_ds = 16'hFFFF; seg_ss = 16'h0000; disp_lo = 8'hFF; disp_hi = 8'hFF;
                ovr_seg = 16'hFFFE;
            end
            default: begin
                reg_bx = 16'h00A5; reg_bp = 16'h7FFF; reg_si = 16'h8001; reg_di = 16'h4000;
                seg_ds = 16'h0FFF; seg_ss = 16'hFFF1; disp_lo = 8'h7F; disp_hi = 8'h80;
                ovr_seg = 16'h8000;
            end
        endcase
    endtask

    // Expected results from the requirement text
    task automatic expect_all();
        int md, rm, w, base, idx, disp, len, exp_ea, exp_pa, segsel, segv;
        bit ss_def;
        md = int'(modrm[7:6]); rm = int'(modrm[2:0]); w = int'(opcode[0]);
        check("R1 out_valid", int'(out_valid), 1);
        check("R9 dir_to_reg", int'(dir_to_reg), int'(opcode[1]));
        check("R9 is_word", int'(is_word), w);
        check("R9 reg_id", int'(reg_id), w * 8 + int'(modrm[5:3]));
        if (md == 3) begin
            check("R8 is_reg", int'(is_reg), 1);
            check("R8 disp_len", int'(disp_len), 0);
            check("R8 rm_reg_id", int'(rm_reg_id), w * 8 + rm);
            check("R8 ea", int'(ea), 0);
            check("R8 pa", int'(pa), 0);
            check("R8 seg_sel", int'(seg_sel), 0);
        end else begin
            ss_def = (rm == 2 || rm == 3 || (rm == 6 && md != 0));
            base = (rm == 0 || rm == 1 || rm == 7) ? int'(reg_bx) :
                   (rm == 2 || rm == 3 || (rm == 6 && md != 0)) ? int'(reg_bp) : 0;
            idx  = (rm == 0 || rm == 2 || rm == 4) ? int'(reg_si) :
                   (rm == 1 || rm == 3 || rm == 5) ? int'(reg_di) : 0;
            if (md == 1) begin
                len = 1;
                disp = (disp_lo >= 8'h80) ? int'(disp_lo) + 32'hFF00 : int'(disp_lo);
            end else if (md == 2 || rm == 6) begin
                len = 2;
                disp = int'(disp_hi) * 256 + int'(disp_lo);
            end else begin
                len = 0;
                disp = 0;
            end
            exp_ea = (base + idx + disp) % 65536;
            if (ovr_en) begin segsel = 2; segv = int'(ovr_seg); end
            else if (ss_def) begin segsel = 1; segv = int'(seg_ss); end
            else begin segsel = 0; segv = int'(seg_ds); end
            exp_pa = (segv * 16 + exp_ea) % 1048576;
            check("R8 is_reg", int'(is_reg), 0);
            check("R8 rm_reg_id", int'(rm_reg_id), 0);
            check((md == 0 && rm == 6) ? "R4 disp_len" : "R2 disp_len", int'(disp_len), len);
            check((md == 0 && rm == 6) ? "R4 ea" : "R3 ea", int'(ea), exp_ea);
            check(ovr_en ? "R6 seg_sel" : "R5 seg_sel", int'(seg_sel), segsel);
            check("R7 pa", int'(pa), exp_pa);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset out_valid", int'(out_valid), 0);
        check("R1 reset ea", int'(ea), 0);
        check("R1 reset pa", int'(pa), 0);
        check("R1 reset disp_len", int'(disp_len), 0);
        rst = 1'b0;
        for (int p = 0; p < 3; p++) begin
            for (int o = 0; o < 2; o++) begin
                for (int m = 0; m < 256; m++) begin
                    load_pattern(p);
                    ovr_en   = o[0];
                    modrm    = m[7:0];
                    opcode   = 8'h88 | 8'((m + p) & 3);
                    in_valid = 1'b1;
                    @(negedge clk);
                    expect_all();
                end
            end
        end
        // R1 idle cycle drops out_valid
        in_valid = 1'b0;
        @(negedge clk);
        check("R1 idle out_valid", int'(out_valid), 0);
        // R1 reset mid-stream clears outputs
        in_valid = 1'b1; modrm = 8'h87;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset out_valid", int'(out_valid), 0);
        check("R1 reset ea", int'(ea), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule